// File: doc/BRIEF.md
# Motor PWM Channel with Staggered Turn-Off

This block produces the drive level of one motor-drive PWM channel. A timer counter advances on a divided version of the bus clock. The divider ratio is 1, 2, 4 or 8. The counter runs over a programmed period and the output is compared against a programmed duty value. Three pulse placements are available: pulses that start at the cycle start, pulses that end at the cycle end, and pulses centred in an up/down count. The up/down placement makes each output cycle twice as long.

High-to-low transitions of the drive level can be postponed by 0 to 3 counter clocks. Low-to-high transitions are never postponed. Channels sharing one supply can each get a different postponement, so their turn-off current peaks do not line up.

Duty, period, placement, postponement and enable are held in shadow copies. These copies refresh only when the counter wraps. A stop request freezes all counting and forces a selectable inactive level. When the request is removed, the channel continues exactly where it left off.

Top module: `mpwm_channel`

## Requirements
- R1: The counter advances once every 2^k bus clocks, where k is the 2-bit value on `presc_i` (0 to 3). The divider restarts from zero whenever the loaded period is zero.
- R2: With `align_i` = 0 (leading), the count runs 0..P-1 and wraps. The drive is active (1) while count < D, where P is the loaded period and D is the loaded duty.
- R3: With `align_i` = 1 (trailing), the count runs 0..P-1 and the drive is active while count >= P-D, so the pulse ends at the wrap.
- R4: With `align_i` = 2 or 3 (centred), the count goes up 0..P-1 and then down P-1..0, with each end value held for two counter clocks. One output cycle is 2P counter clocks, and the drive is active while count < D.
- R5: D = 0 gives a constant inactive-going output (0). D >= P gives a constant 1 with no gaps, whatever the postponement.
- R6: A 1-to-0 transition of the drive is postponed by `delay_i` (0..3) counter clocks. A 0-to-1 transition is not postponed. If the compare asks for a high level again during the postponement, the output stays high.
- R7: Duty, period, placement, postponement and enable are taken from the inputs only at a counter wrap, or on every clock while the loaded period is zero. A cycle never mixes old and new settings.
- R8: When enable is loaded as 0 at a wrap, the output takes `idle_lvl_i` from that wrap on, with no postponement.
- R9: While the loaded period is 0, the output is `idle_lvl_i` and the counter stays at 0. The first nonzero period starts a fresh cycle from count 0.
- R10: While `stop_i` is 1, the counter, divider and postponement state freeze, and one clock later the output is `idle_lvl_i`. After `stop_i` falls, the output continues as if the stopped clocks had not happened.
- R11: During and right after reset, the output equals `idle_lvl_i`. The output is registered, so it reflects the counter state of the previous bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Channel enable (loaded at wrap) |
| stop_i | input | 1 | Stop request: freeze and force inactive level |
| presc_i | input | 2 | Counter clock divider select, ratio 2^presc_i |
| period_i | input | CNT_W | Period in counter clocks (0 = invalid) |
| duty_i | input | CNT_W | Duty in counter clocks |
| align_i | input | 2 | 0 leading, 1 trailing, 2/3 centred |
| delay_i | input | 2 | Falling-edge postponement in counter clocks |
| idle_lvl_i | input | 1 | Level driven when stopped, disabled or period is 0 |
| pwm_o | output | 1 | Drive level |

## Verification
The bench builds the block with CNT_W = 4. With this width, the largest period of 15 and every duty from 0 up to and past the period can be swept quickly. The sweep covers all three placements, every postponement value and every divider ratio, and each run is compared cycle by cycle against a waveform computed arithmetically from the count position. Directed runs add these cases:
- a mid-cycle duty change;
- a disable that lands while a postponed fall is pending;
- a stop window in the middle of a centred cycle;
- a start from a zero period.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    typedef enum logic [1:0] {
        ALN_LEAD   = 2'd0,
        ALN_TRAIL  = 2'd1,
        ALN_CENTER = 2'd2,
        ALN_CENT2  = 2'd3
    } align_e;

    function automatic logic is_center(align_e a);
        return (a == ALN_CENTER) || (a == ALN_CENT2);
    endfunction

endpackage

// File: rtl/mpwm_prescaler.sv
module mpwm_prescaler #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);
    localparam int DIV_W = (2 ** PS_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } ps_state_t;

    ps_state_t        st_d, st_q;
    logic [DIV_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        lim    = DIV_W'((32'd1 << sel) - 32'd1);
        at_lim = (st_q.div >= lim);
        tick   = run && !clr && at_lim;
        st_d   = st_q;
        if (run) begin
            if (clr || at_lim) begin
                st_d.div = '0;
            end else begin
                st_d.div = st_q.div + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: two ticks in a row only happen at divide-by-one
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick) && $past(rst_n)) |-> (sel == '0));

endmodule

// File: rtl/mpwm_timebase.sv
module mpwm_timebase
    import mpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             en_in,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [1:0]       align_in,
    input  logic [1:0]       dly_in,
    output logic [CNT_W-1:0] cnt,
    output logic             per_zero,
    output logic             en_sh,
    output logic [CNT_W-1:0] per_sh,
    output logic [CNT_W-1:0] duty_sh,
    output align_e           align_sh,
    output logic [1:0]       dly_sh
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             en;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        align_e           align;
        logic [1:0]       dly;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      zero_q;
    logic      center;
    logic      top_hit;
    logic      wrap;
    logic      load;

    always_comb begin
        zero_q  = (st_q.per == '0);
        center  = is_center(st_q.align);
        top_hit = !zero_q && (st_q.cnt >= st_q.per - CNT_W'(1));
        wrap    = center ? (st_q.down && st_q.cnt == '0) : top_hit;
        load    = run && (zero_q || (tick && wrap));
        st_d    = st_q;
        if (run) begin
            if (zero_q) begin
                st_d.cnt  = '0;
                st_d.down = 1'b0;
            end else if (tick) begin
                if (wrap) begin
                    st_d.cnt  = '0;
                    st_d.down = 1'b0;
                end else if (!center) begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end else if (!st_q.down) begin
                    if (top_hit) begin
                        st_d.down = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end
        if (load) begin
            st_d.en    = en_in;
            st_d.per   = per_in;
            st_d.duty  = duty_in;
            st_d.align = align_e'(align_in);
            st_d.dly   = dly_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, down: 1'b0, en: 1'b0, per: '0, duty: '0,
                      align: ALN_LEAD, dly: 2'd0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign per_zero = zero_q;
    assign en_sh    = st_q.en;
    assign per_sh   = st_q.per;
    assign duty_sh  = st_q.duty;
    assign align_sh = st_q.align;
    assign dly_sh   = st_q.dly;

    // R2: the count stays inside the loaded period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_q |-> (st_q.cnt < st_q.per));

    // R7: shadow duty only moves on a load
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.duty));

    // R10: counting freezes during stop
    a_r10_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(st_q.cnt));

    // R9: a zero period holds the count at zero
    a_r9_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_q && run) |=> (st_q.cnt == '0));

endmodule

// File: rtl/mpwm_outstage.sv
module mpwm_outstage
    import mpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             per_zero,
    input  logic             en_sh,
    input  logic [CNT_W-1:0] per_sh,
    input  logic [CNT_W-1:0] duty_sh,
    input  align_e           align_sh,
    input  logic [1:0]       dly_sh,
    input  logic             idle_lvl,
    output logic             drive
);
    typedef struct packed {
        logic       level;
        logic [1:0] hold;
        logic       drv;
    } os_state_t;

    os_state_t st_d, st_q;
    logic      raw;
    logic      off;

    always_comb begin
        if (align_sh == ALN_TRAIL) begin
            raw = (duty_sh >= per_sh) || (cnt >= per_sh - duty_sh);
        end else begin
            raw = (cnt < duty_sh);
        end
        off  = !en_sh || per_zero;
        st_d = st_q;
        if (off) begin
            st_d.level = 1'b0;
            st_d.hold  = 2'd0;
        end else if (run) begin
            if (raw) begin
                st_d.level = 1'b1;
                st_d.hold  = 2'd0;
            end else if (st_q.level) begin
                if (st_q.hold >= dly_sh) begin
                    st_d.level = 1'b0;
                end else if (tick) begin
                    st_d.hold = st_q.hold + 2'd1;
                end
            end
        end
        st_d.drv = (!run || off) ? idle_lvl : st_d.level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{level: 1'b0, hold: 2'd0, drv: idle_lvl};
        end else begin
            st_q <= st_d;
        end
    end

    assign drive = st_q.drv;

    // R10: a stop request forces the inactive level on the next clock
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (drive == $past(idle_lvl)));

    // R6: a rising compare reaches the output without postponement
    a_r6_rise_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !off && raw) |=> drive);

    // R6: the postponement counter never passes the programmed value
    a_r6_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!off && !raw && st_q.level) |-> (st_q.hold <= dly_sh));

endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel
    import mpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PS_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             stop_i,
    input  logic [PS_W-1:0]  presc_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [1:0]       align_i,
    input  logic [1:0]       delay_i,
    input  logic             idle_lvl_i,
    output logic             pwm_o
);
    logic             run;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             per_zero;
    logic             en_sh;
    logic [CNT_W-1:0] per_sh;
    logic [CNT_W-1:0] duty_sh;
    align_e           align_sh;
    logic [1:0]       dly_sh;

    assign run = !stop_i;

    mpwm_prescaler #(.PS_W(PS_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (per_zero),
        .sel   (presc_i),
        .tick  (tick)
    );

    mpwm_timebase #(.CNT_W(CNT_W)) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .en_in    (enable_i),
        .per_in   (period_i),
        .duty_in  (duty_i),
        .align_in (align_i),
        .dly_in   (delay_i),
        .cnt      (cnt),
        .per_zero (per_zero),
        .en_sh    (en_sh),
        .per_sh   (per_sh),
        .duty_sh  (duty_sh),
        .align_sh (align_sh),
        .dly_sh   (dly_sh)
    );

    mpwm_outstage #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .cnt      (cnt),
        .per_zero (per_zero),
        .en_sh    (en_sh),
        .per_sh   (per_sh),
        .duty_sh  (duty_sh),
        .align_sh (align_sh),
        .dly_sh   (dly_sh),
        .idle_lvl (idle_lvl_i),
        .drive    (pwm_o)
    );

    // R9: the output is idle whenever the loaded period is zero
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (per_zero && $past(rst_n)) |=> (pwm_o == $past(idle_lvl_i)));

endmodule

// File: tb/mpwm_channel_test.sv
module mpwm_channel_test;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [1:0]       presc_i = 2'd0;
    logic [CNT_W-1:0] period_i = '0;
    logic [CNT_W-1:0] duty_i = '0;
    logic [1:0]       align_i = 2'd0;
    logic [1:0]       delay_i = 2'd0;
    logic             idle_lvl_i = 1'b0;
    logic             pwm_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    mpwm_channel #(.CNT_W(CNT_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .stop_i     (stop_i),
        .presc_i    (presc_i),
        .period_i   (period_i),
        .duty_i     (duty_i),
        .align_i    (align_i),
        .delay_i    (delay_i),
        .idle_lvl_i (idle_lvl_i),
        .pwm_o      (pwm_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1;
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic bit raw_at(int s, int p, int d, int al);
        int m, l, u, c;
        if (s < 0) return 1'b0;
        m = (al >= 2) ? 2 : 1;
        l = m * p;
        u = s % l;
        c = (al >= 2 && u >= p) ? (2 * p - 1 - u) : u;
        if (al == 1) return (d >= p) ? 1'b1 : (c >= p - d);
        return c < d;
    endfunction

    function automatic bit level_at(int s, int p, int d0, int d1, int al, int dl);
        int l;
        bit v;
        l = ((al >= 2) ? 2 : 1) * p;
        v = 1'b0;
        for (int j = 0; j <= dl; j++) begin
            v = v | raw_at(s - j, p, ((s - j) < l) ? d0 : d1, al);
        end
        return v;
    endfunction

    task automatic check_bit(string tag, logic got, logic exp);
        checks = checks + 1;
        if (got !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual %b expected %b", tag, got, exp);
        end
    endtask

    // One run from reset; compares every cycle, counts as one check.
    task automatic run_case(string tag, int p, int d0, int d1, int al, int dl,
                            int ps, bit idl, int pre, int ss, int sl, bit dis,
                            int ncyc);
        int  div, l, a, bad, s;
        bit  pstop, stp;
        logic exp;
        div = 1 << ps;
        l   = ((al >= 2) ? 2 : 1) * p;
        @(negedge clk);
        rst_n      = 1'b0;
        enable_i   = 1'b1;
        stop_i     = 1'b0;
        presc_i    = 2'(ps);
        period_i   = (pre > 0) ? '0 : CNT_W'(p);
        duty_i     = CNT_W'(d0);
        align_i    = 2'(al);
        delay_i    = 2'(dl);
        idle_lvl_i = idl;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        bad = 0;
        for (int k = 1; k <= pre; k++) begin
            @(negedge clk);
            if (pwm_o !== idl) begin
                if (bad == 0) $display("FAIL %s R9 pre k=%0d: actual %b expected %b", tag, k, pwm_o, idl);
                bad++;
            end
            if (k == pre) period_i = CNT_W'(p);
        end
        a = 0;
        pstop = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (p == 0 || c == 0 || pstop) begin
                exp = idl;
            end else begin
                s = (a - 1 + (pstop ? 1 : 0)) / div;
                s = a_prev_step(a, div);
                if (dis && s >= l) exp = idl;
                else exp = level_at(s, p, d0, d1, al, dl);
            end
            if (pwm_o !== exp) begin
                if (bad == 0) $display("FAIL %s cycle %0d: actual %b expected %b", tag, c, pwm_o, exp);
                bad++;
            end
            stp = (c >= ss) && (c < ss + sl);
            stop_i = stp;
            if (c == 1) begin
                duty_i = CNT_W'(d1);
                if (dis) enable_i = 1'b0;
            end
            if (c > 0) a = a + (pstop ? 0 : 1);
            pstop = stp;
        end
        stop_i = 1'b0;
        checks = checks + 1;
        if (bad != 0) begin
            failures = failures + 1;
            $display("FAIL %s: actual %0d mismatching cycles, expected 0", tag, bad);
        end
    endtask

    // a holds the count of running cycles before the previous cycle.
    function automatic int a_prev_step(int a, int div);
        return a / div;
    endfunction

    initial begin
        // R11: output at idle level during reset, for both idle values
        rst_n = 1'b0;
        idle_lvl_i = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R11 reset idle=1", pwm_o, 1'b1);
        idle_lvl_i = 1'b0;
        repeat (2) @(negedge clk);
        check_bit("R11 reset idle=0", pwm_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R11 after reset", pwm_o, 1'b0);

        // R9: zero period gives idle level throughout
        run_case("R9 zero period", 0, 3, 3, 0, 0, 0, 1'b1, 0, 999, 0, 1'b0, 40);
        // R9: zero period then a fresh start
        run_case("R9 restart", 4, 2, 2, 0, 1, 1, 1'b1, 12, 999, 0, 1'b0, 60);

        // R1 R2 R3 R4 R5 R6: sweep placements, delays, duties and dividers
        foreach (sweep_p[i]) begin
            for (int al = 0; al < 3; al++) begin
                for (int dl = 0; dl < 4; dl++) begin
                    for (int d = 0; d <= sweep_p[i] + 1 && d <= 15; d++) begin
                        int ps, l;
                        ps = (d + dl + al) % 4;
                        l  = ((al >= 2) ? 2 : 1) * sweep_p[i];
                        run_case($sformatf("R1/R2/R3/R4/R5/R6 sweep p=%0d d=%0d al=%0d dl=%0d ps=%0d",
                                 sweep_p[i], d, al, dl, ps),
                                 sweep_p[i], d, d, al, dl, ps, 1'b0, 0, 999, 0, 1'b0,
                                 2 * l * (1 << ps) + 8);
                    end
                end
            end
        end

        // R4: placement code 3 also centred
        run_case("R4 code3", 5, 2, 2, 3, 1, 1, 1'b0, 0, 999, 0, 1'b0, 50);

        // R7: duty change mid-cycle takes effect at the wrap
        run_case("R7 lead change", 6, 2, 5, 0, 1, 1, 1'b0, 0, 999, 0, 1'b0, 40);
        run_case("R7 trail change", 6, 3, 0, 1, 2, 0, 1'b0, 0, 999, 0, 1'b0, 30);
        // R8: disable at the wrap, no postponement of the pending fall
        run_case("R8 disable", 6, 2, 2, 1, 3, 0, 1'b0, 0, 999, 0, 1'b1, 30);
        run_case("R8 disable idle1", 5, 3, 3, 0, 2, 1, 1'b1, 0, 999, 0, 1'b1, 40);
        // R10: stop window mid-cycle, resume in step
        run_case("R10 stop", 5, 3, 3, 2, 2, 1, 1'b1, 0, 13, 9, 1'b0, 70);
        run_case("R10 stop lead", 7, 4, 4, 0, 3, 0, 1'b0, 0, 5, 6, 1'b0, 40);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int sweep_p[4] = '{1, 2, 5, 15};

endmodule